// File: doc/BRIEF.md
# Ping-Pong Sample Bank Controller

This block holds two equal banks of sample storage and shares them between a streaming audio port and a processor. At any time the port owns one bank and the processor owns the other. On each port sample strobe, the port writes one received sample into its bank at the current counter offset. In the same strobe it fetches the playback sample that was stored at that offset. The processor reads received samples from its own bank and can overwrite them in place with playback samples.

When the port has handled the programmed number of samples, the banks trade owners on that same clock edge. The swap can raise a level interrupt and a one-cycle DMA request. The block supplies the bank-select address bit on both sides, so the processor always uses one fixed offset window and never needs to know which physical bank it owns.

If the processor has not signalled completion since the previous swap, the swap also sets a sticky overrun flag.

Top module: `smp_pingpong`

## Requirements
- R1: After reset `cur_bank_o` is 0, `irq_o`, `dma_req_o` and `overrun_o` are 0, `prt_tx_data_o` and `cpu_rdata_o` are 0, and the sample counter is 0.
- R2: On a clock edge with `prt_valid_i` high, `prt_rx_data_i` is stored in the port-owned bank (`cur_bank_o`) at the counter offset. From that edge on, `prt_tx_data_o` shows the word that location held before the store. Without a strobe, `prt_tx_data_o` holds its value.
- R3: Each strobe advances the counter by one, modulo 2^OFS_W. The effective count is `cfg_count_i`, or 2^OFS_W when `cfg_count_i` is 0. A strobe that finds the counter at effective count minus 1 sets the counter to 0 and inverts `cur_bank_o` on that same edge. `cur_bank_o` changes at no other time.
- R4: A processor access (`cpu_req_i`) at offset `cpu_addr_i` targets the bank opposite `cur_bank_o`. A write (`cpu_we_i`=1) stores `cpu_wdata_i`. A read puts the stored word on `cpu_rdata_o` from the next edge on. `cpu_rdata_o` holds its value on writes and idle cycles.
- R5: A processor access at an offset greater than or equal to the effective count is ignored when it is a write, and returns 0 on `cpu_rdata_o` when it is a read.
- R6: A swap with `cfg_irq_en_i` high sets `irq_o`. `irq_o` stays high until a cycle with `irq_ack_i` high and no new enabled swap.
- R7: A swap with `cfg_dma_en_i` high makes `dma_req_o` high for exactly the one cycle that follows the swap edge.
- R8: A swap sets `overrun_o` unless `cpu_done_i` was high in some cycle since the previous swap, including the swap cycle itself. `overrun_o` stays set until `ovr_clr_i` is high in a cycle without such a late swap; a late swap wins over a clear.
- R9: Every swap consumes the completion mark, so each bank period needs its own `cpu_done_i` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_count_i | input | OFS_W+1 | Samples per bank period, 0 selects full bank |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| cfg_dma_en_i | input | 1 | DMA request enable |
| prt_valid_i | input | 1 | Port sample strobe |
| prt_rx_data_i | input | DATA_W | Received sample to store |
| prt_tx_data_o | output | DATA_W | Playback sample fetched by the last strobe |
| cpu_req_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | Processor write when high |
| cpu_addr_i | input | OFS_W | Offset within the processor window |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_rdata_o | output | DATA_W | Processor read data |
| cpu_done_i | input | 1 | Processor signals its bank work is complete |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| ovr_clr_i | input | 1 | Write-one-clear strobe for the overrun flag |
| irq_o | output | 1 | Swap interrupt, level |
| dma_req_o | output | 1 | Swap DMA request, one-cycle pulse |
| overrun_o | output | 1 | Sticky late-processor flag |
| cur_bank_o | output | 1 | Bank currently owned by the port |

## Verification
Every result is registered, so each one is due on the first edge after the inputs that cause it. This covers the fetched playback word, processor read data, the bank bit, the interrupt, the DMA pulse and the overrun flag. The bench drives each input set on a falling edge and lets one rising edge pass. It advances its reference model exactly once per edge and compares all six outputs at the following falling edge. The DMA pulse is therefore due in the single cycle after the swap edge and is checked low again one sample later. Storage that was never written is marked unknown in the model, and data compares are skipped for it.

// File: rtl/smp_pp_pkg.sv
package smp_pp_pkg;

  // Events produced by the port sequencer in one cycle
  typedef struct packed {
    logic swap;   // bank ownership changes at this edge
    logic late;   // swap without a completion mark
  } swap_evt_t;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

endpackage

// File: rtl/smp_pp_mem.sv
// Two-bank storage: bank bit is the address MSB; two write ports, two comb reads.
module smp_pp_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 6
) (
  input  logic              clk_i,
  input  logic              a_we_i,
  input  logic [OFS_W:0]    a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_we_i,
  input  logic [OFS_W:0]    b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);

  localparam int unsigned WORDS = 2 ** (OFS_W + 1);

  logic [DATA_W-1:0] mem_q [WORDS];

  // Ports never address the same bank, so write order does not matter
  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
  end

  assign a_rdata_o = mem_q[a_addr_i];
  assign b_rdata_o = mem_q[b_addr_i];

endmodule

// File: rtl/smp_pp_seq.sv
// Port-side sample counter and bank owner.
module smp_pp_seq
  import smp_pp_pkg::*;
#(
  parameter int unsigned OFS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OFS_W:0]   eff_cnt_i,
  input  logic             ready_i,
  output logic [OFS_W-1:0] cnt_o,
  output bank_e            bank_o,
  output swap_evt_t        evt_o
);

  logic [OFS_W-1:0] cnt_q;
  bank_e            bank_q;
  logic             at_last;

  assign at_last    = ({1'b0, cnt_q} == (eff_cnt_i - 1'b1));
  assign evt_o.swap = valid_i & at_last;
  assign evt_o.late = valid_i & at_last & ~ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bank_q <= BANK_A;
    end else if (valid_i) begin
      if (at_last) begin
        cnt_q  <= '0;
        bank_q <= bank_e'(~bank_q);
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign bank_o = bank_q;

endmodule

// File: rtl/smp_pp_evt.sv
// Swap events: interrupt level, DMA pulse, completion mark and overrun flag.
module smp_pp_evt
  import smp_pp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  swap_evt_t evt_i,
  input  logic      irq_en_i,
  input  logic      dma_en_i,
  input  logic      irq_ack_i,
  input  logic      done_i,
  input  logic      ovr_clr_i,
  output logic      ready_o,
  output logic      irq_o,
  output logic      dma_o,
  output logic      ovr_o
);

  logic ready_q, irq_q, dma_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
      dma_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      // swap consumes the mark; a done in the swap cycle still counts for it
      if (evt_i.swap)  ready_q <= 1'b0;
      else if (done_i) ready_q <= 1'b1;

      if (evt_i.swap && irq_en_i) irq_q <= 1'b1;
      else if (irq_ack_i)         irq_q <= 1'b0;

      dma_q <= evt_i.swap & dma_en_i;

      if (evt_i.late)     ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  // done in the swap cycle saves the period
  assign ready_o = ready_q | done_i;
  assign irq_o   = irq_q;
  assign dma_o   = dma_q;
  assign ovr_o   = ovr_q;

endmodule

// File: rtl/smp_pp_win.sv
// Processor window: bank remap, range limit, registered read data.
module smp_pp_win
  import smp_pp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFS_W:0]    eff_cnt_i,
  input  bank_e             port_bank_i,
  output logic              mem_we_o,
  output logic [OFS_W:0]    mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic              in_rng;
  logic [DATA_W-1:0] rdata_q;

  assign in_rng      = ({1'b0, addr_i} < eff_cnt_i);
  assign mem_addr_o  = {~port_bank_i, addr_i};
  assign mem_we_o    = req_i & we_i & in_rng;
  assign mem_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= in_rng ? mem_rdata_i : '0;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/smp_pingpong.sv
module smp_pingpong
  import smp_pp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFS_W:0]    cfg_count_i,
  input  logic              cfg_irq_en_i,
  input  logic              cfg_dma_en_i,
  input  logic              prt_valid_i,
  input  logic [DATA_W-1:0] prt_rx_data_i,
  output logic [DATA_W-1:0] prt_tx_data_o,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [OFS_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              cpu_done_i,
  input  logic              irq_ack_i,
  input  logic              ovr_clr_i,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              overrun_o,
  output logic              cur_bank_o
);

  localparam logic [OFS_W:0] FULL_CNT = {1'b1, {OFS_W{1'b0}}};

  logic [OFS_W:0]    eff_cnt;
  logic [OFS_W-1:0]  cnt;
  bank_e             port_bank;
  swap_evt_t         evt;
  logic              ready;
  logic [DATA_W-1:0] prt_rd;
  logic [DATA_W-1:0] tx_q;
  logic              cpu_mwe;
  logic [OFS_W:0]    cpu_maddr;
  logic [DATA_W-1:0] cpu_mwdata;
  logic [DATA_W-1:0] cpu_mrdata;

  assign eff_cnt = (cfg_count_i == '0) ? FULL_CNT : cfg_count_i;

  smp_pp_seq #(.OFS_W(OFS_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (prt_valid_i),
    .eff_cnt_i (eff_cnt),
    .ready_i   (ready),
    .cnt_o     (cnt),
    .bank_o    (port_bank),
    .evt_o     (evt)
  );

  smp_pp_evt u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .irq_en_i  (cfg_irq_en_i),
    .dma_en_i  (cfg_dma_en_i),
    .irq_ack_i (irq_ack_i),
    .done_i    (cpu_done_i),
    .ovr_clr_i (ovr_clr_i),
    .ready_o   (ready),
    .irq_o     (irq_o),
    .dma_o     (dma_req_o),
    .ovr_o     (overrun_o)
  );

  smp_pp_win #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (cpu_req_i),
    .we_i        (cpu_we_i),
    .addr_i      (cpu_addr_i),
    .wdata_i     (cpu_wdata_i),
    .eff_cnt_i   (eff_cnt),
    .port_bank_i (port_bank),
    .mem_we_o    (cpu_mwe),
    .mem_addr_o  (cpu_maddr),
    .mem_wdata_o (cpu_mwdata),
    .mem_rdata_i (cpu_mrdata),
    .rdata_o     (cpu_rdata_o)
  );

  smp_pp_mem #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_mem (
    .clk_i     (clk_i),
    .a_we_i    (prt_valid_i),
    .a_addr_i  ({port_bank, cnt}),
    .a_wdata_i (prt_rx_data_i),
    .a_rdata_o (prt_rd),
    .b_we_i    (cpu_mwe),
    .b_addr_i  (cpu_maddr),
    .b_wdata_i (cpu_mwdata),
    .b_rdata_o (cpu_mrdata)
  );

  // playback word fetched before the store overwrites it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tx_q <= '0;
    else if (prt_valid_i) tx_q <= prt_rd;
  end

  assign prt_tx_data_o = tx_q;
  assign cur_bank_o    = port_bank;

endmodule

// File: rtl/smp_pingpong_chk.sv
module smp_pingpong_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OFS_W:0]    cfg_count_i,
  input logic              cfg_irq_en_i,
  input logic              prt_valid_i,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [OFS_W-1:0]  cpu_addr_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              irq_ack_i,
  input logic              ovr_clr_i,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic              overrun_o,
  input logic              cur_bank_o
);

  logic oor_rd;
  assign oor_rd = cpu_req_i && !cpu_we_i &&
                  (cfg_count_i != '0) && ({1'b0, cpu_addr_i} >= cfg_count_i);

  p_bank_needs_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_bank_o != $past(cur_bank_o)) |-> $past(prt_valid_i));

  p_oor_read_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_rd |=> (cpu_rdata_o == '0));

  p_irq_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  p_irq_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cfg_irq_en_i));

  p_dma_on_swap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (cur_bank_o != $past(cur_bank_o)));

  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  p_ovr_on_swap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> (cur_bank_o != $past(cur_bank_o)));

endmodule

bind smp_pingpong smp_pingpong_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_count_i  (cfg_count_i),
  .cfg_irq_en_i (cfg_irq_en_i),
  .prt_valid_i  (prt_valid_i),
  .cpu_req_i    (cpu_req_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_rdata_o  (cpu_rdata_o),
  .irq_ack_i    (irq_ack_i),
  .ovr_clr_i    (ovr_clr_i),
  .irq_o        (irq_o),
  .dma_req_o    (dma_req_o),
  .overrun_o    (overrun_o),
  .cur_bank_o   (cur_bank_o)
);

// File: tb/sim_smp_pingpong.sv
`timescale 1ns/1ps
module sim_smp_pingpong;

  localparam int DW = 32;
  localparam int OW = 6;
  localparam int D  = 1 << OW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [OW:0]   cfg_count = '0;
  logic          irq_en = 1'b0, dma_en = 1'b0;
  logic          pv = 1'b0;
  logic [DW-1:0] rx = '0;
  logic [DW-1:0] tx;
  logic          req = 1'b0, we = 1'b0;
  logic [OW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd;
  logic          done = 1'b0, ack = 1'b0, clr = 1'b0;
  logic          irq, dma, ovr, bank;

  always #2.5 clk = ~clk;

  smp_pingpong #(.DATA_W(DW), .OFS_W(OW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_count_i(cfg_count),
    .cfg_irq_en_i(irq_en), .cfg_dma_en_i(dma_en),
    .prt_valid_i(pv), .prt_rx_data_i(rx), .prt_tx_data_o(tx),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wd),
    .cpu_rdata_o(rd), .cpu_done_i(done), .irq_ack_i(ack), .ovr_clr_i(clr),
    .irq_o(irq), .dma_req_o(dma), .overrun_o(ovr), .cur_bank_o(bank)
  );

  int n_chk = 0, n_err = 0;

  // reference model state
  logic [DW-1:0] m_mem [2*D];
  bit            m_kn  [2*D];
  int            m_cnt = 0;
  bit            m_bank = 0, m_irq = 0, m_dma = 0, m_ovr = 0, m_rdy = 0;
  logic [DW-1:0] m_tx = '0, m_rd = '0;
  bit            m_tx_kn = 1, m_rd_kn = 1;
  string         m_rd_tag = "R4";

  function automatic int eff(logic [OW:0] c);
    return (c == 0) ? D : int'(c);
  endfunction

  task automatic chk(string rq, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic model_edge();
    int  e    = eff(cfg_count);
    bit  swp  = pv && (m_cnt == e - 1);
    int  pidx = int'(m_bank) * D + m_cnt;
    int  cidx = int'(!m_bank) * D + int'(addr);
    bit  inr  = int'(addr) < e;
    if (req && !we) begin
      m_rd_tag = inr ? "R4" : "R5";
      if (inr) begin m_rd = m_mem[cidx]; m_rd_kn = m_kn[cidx]; end
      else     begin m_rd = '0;          m_rd_kn = 1; end
    end
    if (pv) begin
      m_tx = m_mem[pidx]; m_tx_kn = m_kn[pidx];
      m_mem[pidx] = rx; m_kn[pidx] = 1;
    end
    if (req && we && inr) begin m_mem[cidx] = wd; m_kn[cidx] = 1; end
    if (swp && irq_en) m_irq = 1; else if (ack) m_irq = 0;
    m_dma = swp && dma_en;
    if (swp && !(m_rdy || done)) m_ovr = 1; else if (clr) m_ovr = 0;
    if (swp) m_rdy = 0; else if (done) m_rdy = 1;
    if (pv) begin
      if (swp) begin m_cnt = 0; m_bank = !m_bank; end
      else m_cnt = (m_cnt + 1) % D;
    end
  endtask

  task automatic compare();
    chk("R3", "cur_bank", {31'b0, bank}, {31'b0, m_bank});
    chk("R6", "irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R7", "dma_req", {31'b0, dma}, {31'b0, m_dma});
    chk("R8,R9", "overrun", {31'b0, ovr}, {31'b0, m_ovr});
    if (m_tx_kn) chk("R2", "tx_data", tx, m_tx);
    if (m_rd_kn) chk(m_rd_tag, "rdata", rd, m_rd);
  endtask

  // inputs set by caller at a falling edge; one rising edge; compare at next fall
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    pv = 0; req = 0; we = 0; done = 0; ack = 0; clr = 0;
  endtask

  task automatic port(logic [DW-1:0] v);
    pv = 1; rx = v; step();
  endtask

  task automatic cpu_wr(int a, logic [DW-1:0] v);
    req = 1; we = 1; addr = OW'(a); wd = v; step();
  endtask

  task automatic cpu_rd(int a);
    req = 1; we = 0; addr = OW'(a); step();
  endtask

  initial begin
    #(5ns * 150000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2*D; i++) begin m_mem[i] = '0; m_kn[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cur_bank", {31'b0, bank}, 32'd0);
    chk("R1", "irq", {31'b0, irq}, 32'd0);
    chk("R1", "dma_req", {31'b0, dma}, 32'd0);
    chk("R1", "overrun", {31'b0, ovr}, 32'd0);
    chk("R1", "tx_data", tx, 32'd0);
    chk("R1", "rdata", rd, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // directed: count 4, fill bank 0, swap with both events, late processor
    cfg_count = 4; irq_en = 1; dma_en = 1;
    for (int i = 0; i < 4; i++) port(32'hA000_0000 + i);   // R3 swap on 4th
    step();                                                 // R7 pulse gone
    for (int i = 0; i < 6; i++) cpu_rd(i);                  // R4 and R5 (i>=4 zero)
    cpu_wr(1, 32'h1111_2222);                               // R4 in place
    cpu_wr(5, 32'hDEAD_BEEF);                               // R5 ignored
    ack = 1; step();                                        // R6 ack
    done = 1; step();
    for (int i = 0; i < 4; i++) port(32'hB000_0000 + i);    // in-time swap
    for (int i = 0; i < 4; i++) port(32'hC000_0000 + i);    // R2 playback of 0x1111_2222; R9 late
    clr = 1; step();                                        // R8 clear
    cfg_count = 8;
    for (int i = 0; i < 8; i++) cpu_rd(i);                  // R5 offset 5 kept old content
    // swap with done in the same cycle counts as in time (R8)
    for (int i = 0; i < 7; i++) port(32'hD000_0000 + i);
    done = 1; port(32'hD000_0007);
    // swap wins over clear and ack
    for (int i = 0; i < 7; i++) port(i);
    clr = 1; ack = 1; port(32'h7);
    // count 1 swaps every strobe; count 0 means full bank
    cfg_count = 1;
    for (int i = 0; i < 4; i++) port(32'hE000_0000 + i);
    cfg_count = 0;
    for (int i = 0; i < D; i++) port(32'hF000_0000 + i);
    cpu_rd(D - 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if (m_cnt == 0 && ($urandom % 40) == 0) cfg_count = (OW+1)'($urandom % 10);
      if (($urandom % 50) == 0) irq_en = $urandom;
      if (($urandom % 50) == 0) dma_en = $urandom;
      pv   = ($urandom % 3) != 0;
      rx   = $urandom;
      req  = $urandom;
      we   = $urandom;
      addr = OW'($urandom % 12);
      wd   = $urandom;
      done = ($urandom % 8) == 0;
      ack  = ($urandom % 6) == 0;
      clr  = ($urandom % 10) == 0;
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule